// File: doc/BRIEF.md
# Integer Execution Unit with Overflow Trap

This block is the purely combinational integer unit of a small 32-bit core. It takes the two register read values, the 5-bit constant shift amount and the 16-bit immediate field of the current instruction, plus the primary opcode and function fields. From these it returns a 32-bit result, a register write-enable and a signed-overflow exception flag in the same cycle. The unit decodes the opcode and function fields itself.

Each arithmetic operation comes in a trapping form and a non-trapping form. A trapping add or subtract that overflows raises the exception flag and drops the write-enable, so the destination register keeps its old value. Encodings outside the supported set produce a zero result, no write and no exception. Those encodings include division, loads, stores, jumps and branches, which other blocks handle.

Top module: `int_exec_unit`

## Requirements
- R1: The trapping forms flag signed two's-complement overflow and drive write-enable low when they do. They are add (opcode 0x00, funct 0x20), subtract (opcode 0x00, funct 0x22) and add-immediate (opcode 0x08). In every case the result shows the wrapped sum or difference.
- R2: The non-trapping forms never raise overflow and always write the wrapped value. They are add (funct 0x21), subtract (funct 0x23) and add-immediate (opcode 0x09).
- R3: The immediate is zero-extended for and-immediate (0x0C), or-immediate (0x0D) and xor-immediate (0x0E). It is sign-extended from bit 15 for add-immediate (0x08) and signed set-less-than immediate (0x0A).
- R4: Unsigned set-less-than immediate (opcode 0x0B) first sign-extends the immediate. It then compares register s and that value as unsigned numbers.
- R5: The set-less-than operations return 1 or 0 in bit 0 with bits 31:1 cleared. These are signed register (funct 0x2A), unsigned register (funct 0x2B) and both immediate forms.
- R6: The variable shifts take their distance from bits 4:0 of register s only, and the upper bits have no effect. They are left (funct 0x04), logical right (0x06) and arithmetic right (0x07).
- R7: The arithmetic right shifts fill vacated bits with bit 31 of register t. These are the constant form (funct 0x03) and the variable form. Left shifts (funct 0x00) and logical right shifts (funct 0x02) fill with zeros. All shifts act on register t.
- R8: Load-upper (opcode 0x0F) returns the immediate in bits 31:16 with bits 15:0 cleared, whatever the operands are.
- R9: Multiply (funct 0x18) returns the low 32 bits of the product, writes, and never raises overflow.
- R10: The all-zero instruction word with zero operands gives a zero result and no overflow. In that case it acts as a no-operation.
- R11: Any other encoding gives result 0, write-enable 0 and overflow 0. This includes divide (funct 0x1A), jump-register (funct 0x08) and load (opcode 0x23).
- R12: Register and, or, xor and nor (funct 0x24 to 0x27) return the bitwise function of registers s and t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | Register s read value |
| opB | input | 32 | Register t read value |
| shamt | input | 5 | Constant shift distance field |
| imm | input | 16 | Immediate field |
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function field for register-format words |
| result | output | 32 | Computed value |
| writeEn | output | 1 | Destination register may be written |
| overflow | output | 1 | Signed overflow exception |

## Verification
The adders are driven with operand pairs on both sides of the signed boundary. This shows that trapping and non-trapping forms differ only in the flag and the write-enable, and that add and subtract detect overflow on the correct sign patterns. The immediates use values with bit 15 set, so sign extension and zero extension give different answers. One unsigned-immediate compare is right only when extension happens before the unsigned test. The variable shifts receive register s values with upper bits set. The shifts also receive register t values with bit 31 set, which separates the fill rules. The encodings handled elsewhere are checked for a silent zero output.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_SLT, OP_SLTU, OP_AND, OP_OR, OP_XOR,
    OP_NOR, OP_LUI, OP_SLL, OP_SRL, OP_SRA, OP_MUL
  } aluOp_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    aluOp_e op;
    logic   useImm;    // second operand is the extended immediate
    logic   signExt;   // immediate is sign-extended
    logic   varShift;  // shift distance comes from register s
    logic   trapOvf;   // signed overflow raises the exception
    logic   regWrite;  // encoding is supported and writes a register
  } ctrlStrobes_t;

endpackage

// File: rtl/int_exec_ctrl.sv
module int_exec_ctrl
  import int_exec_pkg::*;
(
  input  logic [5:0]   opcode,
  input  logic [5:0]   funct,
  output ctrlStrobes_t ctl
);

  always_comb begin
    ctl = '0;
    if (opcode == 6'h00) begin
      ctl.regWrite = 1'b1;
      unique case (funct)
        6'h00: ctl.op = OP_SLL;
        6'h02: ctl.op = OP_SRL;
        6'h03: ctl.op = OP_SRA;
        6'h04: begin ctl.op = OP_SLL; ctl.varShift = 1'b1; end
        6'h06: begin ctl.op = OP_SRL; ctl.varShift = 1'b1; end
        6'h07: begin ctl.op = OP_SRA; ctl.varShift = 1'b1; end
        6'h18: ctl.op = OP_MUL;
        6'h20: begin ctl.op = OP_ADD; ctl.trapOvf = 1'b1; end
        6'h21: ctl.op = OP_ADD;
        6'h22: begin ctl.op = OP_SUB; ctl.trapOvf = 1'b1; end
        6'h23: ctl.op = OP_SUB;
        6'h24: ctl.op = OP_AND;
        6'h25: ctl.op = OP_OR;
        6'h26: ctl.op = OP_XOR;
        6'h27: ctl.op = OP_NOR;
        6'h2a: ctl.op = OP_SLT;
        6'h2b: ctl.op = OP_SLTU;
        default: ctl.regWrite = 1'b0;
      endcase
    end else begin
      ctl.regWrite = 1'b1;
      ctl.useImm   = 1'b1;
      unique case (opcode)
        6'h08: begin ctl.op = OP_ADD;  ctl.signExt = 1'b1; ctl.trapOvf = 1'b1; end
        6'h09: begin ctl.op = OP_ADD;  ctl.signExt = 1'b1; end
        6'h0a: begin ctl.op = OP_SLT;  ctl.signExt = 1'b1; end
        6'h0b: begin ctl.op = OP_SLTU; ctl.signExt = 1'b1; end
        6'h0c: ctl.op = OP_AND;
        6'h0d: ctl.op = OP_OR;
        6'h0e: ctl.op = OP_XOR;
        6'h0f: ctl.op = OP_LUI;
        default: begin ctl.regWrite = 1'b0; ctl.useImm = 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/int_exec_datapath.sv
module int_exec_datapath
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  ctrlStrobes_t               ctl,
  input  logic [DATA_W-1:0]          opA,
  input  logic [DATA_W-1:0]          opB,
  input  logic [$clog2(DATA_W)-1:0]  shamt,
  input  logic [IMM_W-1:0]           imm,
  output logic [DATA_W-1:0]          result,
  output logic                       overflow
);

  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int EXT_W   = DATA_W - IMM_W;
  localparam int MSB     = DATA_W - 1;

  logic [DATA_W-1:0]  immExt, bOperand, sum, diff, mulLow;
  logic [SHAMT_W-1:0] shDist;
  logic               ovfAdd, ovfSub, isLeft, fillBit;
  logic [DATA_W-1:0]  shIn, shOut, shRev;
  logic [DATA_W-1:0]  stage [SHAMT_W+1];

  assign immExt   = ctl.signExt ? {{EXT_W{imm[IMM_W-1]}}, imm} : {{EXT_W{1'b0}}, imm};
  assign bOperand = ctl.useImm ? immExt : opB;

  assign sum    = opA + bOperand;
  assign diff   = opA - bOperand;
  assign mulLow = opA * bOperand;

  assign ovfAdd = (opA[MSB] == bOperand[MSB]) && (sum[MSB]  != opA[MSB]);
  assign ovfSub = (opA[MSB] != bOperand[MSB]) && (diff[MSB] != opA[MSB]);

  // one right-shifting barrel; left shifts mirror the word in and out
  assign shDist  = ctl.varShift ? opA[SHAMT_W-1:0] : shamt;
  assign isLeft  = (ctl.op == OP_SLL);
  assign fillBit = (ctl.op == OP_SRA) ? opB[MSB] : 1'b0;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      shIn[i]  = isLeft ? opB[MSB-i] : opB[i];
      shRev[i] = stage[SHAMT_W][MSB-i];
    end
  end

  assign stage[0] = shIn;
  for (genvar s = 0; s < SHAMT_W; s++) begin : g_shStage
    localparam int STEP = 1 << s;
    assign stage[s+1] = shDist[s] ? {{STEP{fillBit}}, stage[s][MSB:STEP]} : stage[s];
  end

  assign shOut = isLeft ? shRev : stage[SHAMT_W];

  always_comb begin
    result   = '0;
    overflow = 1'b0;
    unique case (ctl.op)
      OP_ADD:  begin result = sum;  overflow = ctl.trapOvf & ovfAdd; end
      OP_SUB:  begin result = diff; overflow = ctl.trapOvf & ovfSub; end
      OP_SLT:  result = {{(DATA_W-1){1'b0}}, ($signed(opA) < $signed(bOperand))};
      OP_SLTU: result = {{(DATA_W-1){1'b0}}, (opA < bOperand)};
      OP_AND:  result = opA & bOperand;
      OP_OR:   result = opA | bOperand;
      OP_XOR:  result = opA ^ bOperand;
      OP_NOR:  result = ~(opA | bOperand);
      OP_LUI:  result = {imm, {EXT_W{1'b0}}};
      OP_SLL, OP_SRL, OP_SRA: result = shOut;
      OP_MUL:  result = mulLow;
      default: result = '0;
    endcase
  end

  // R7: arithmetic right shifts of a negative word keep bit 31 set
  always_comb begin
    p_sra_sign_fill_r7: assert (!(ctl.op == OP_SRA && opB[MSB]) || result[MSB])
      else $error("arithmetic shift lost the sign bit");
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0]         opA,
  input  logic [DATA_W-1:0]         opB,
  input  logic [$clog2(DATA_W)-1:0] shamt,
  input  logic [IMM_W-1:0]          imm,
  input  logic [5:0]                opcode,
  input  logic [5:0]                funct,
  output logic [DATA_W-1:0]         result,
  output logic                      writeEn,
  output logic                      overflow
);

  ctrlStrobes_t ctl;

  int_exec_ctrl u_ctrl (
    .opcode (opcode),
    .funct  (funct),
    .ctl    (ctl)
  );

  int_exec_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .ctl      (ctl),
    .opA      (opA),
    .opB      (opB),
    .shamt    (shamt),
    .imm      (imm),
    .result   (result),
    .overflow (overflow)
  );

  // a trapped overflow cancels the register write
  assign writeEn = ctl.regWrite & ~overflow;

  always_comb begin
    p_no_overflow_r2: assert (ctl.trapOvf || !overflow)
      else $error("non-trapping form raised overflow");
    p_mul_no_trap_r9: assert (ctl.op != OP_MUL || !overflow)
      else $error("multiply raised overflow");
    p_lui_low_clear_r8: assert (ctl.op != OP_LUI || result[DATA_W-IMM_W-1:0] == '0)
      else $error("load-upper left low bits set");
    p_set_bool_r5: assert (!(ctl.op inside {OP_SLT, OP_SLTU}) || result[DATA_W-1:1] == '0)
      else $error("set-less-than result not boolean");
    p_unsupported_quiet_r11: assert (ctl.regWrite || (result == '0 && !overflow && !writeEn))
      else $error("unsupported encoding not silent");
  end

endmodule

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb;

  typedef struct packed {
    logic [5:0]  opc;
    logic [5:0]  fn;
    logic [4:0]  sh;
    logic [15:0] imm;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        we;
    logic        ov;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VECS [NV] = '{
    // R1 trapping forms
    '{6'h00, 6'h20, 5'd0, 16'h0000, 32'h7fffffff, 32'h00000001, 32'h80000000, 1'b0, 1'b1, 4'd1},
    '{6'h00, 6'h20, 5'd0, 16'h0000, 32'h00000005, 32'h00000007, 32'h0000000c, 1'b1, 1'b0, 4'd1},
    '{6'h00, 6'h20, 5'd0, 16'h0000, 32'h80000000, 32'h80000000, 32'h00000000, 1'b0, 1'b1, 4'd1},
    '{6'h00, 6'h22, 5'd0, 16'h0000, 32'h80000000, 32'h00000001, 32'h7fffffff, 1'b0, 1'b1, 4'd1},
    '{6'h00, 6'h22, 5'd0, 16'h0000, 32'h00000000, 32'h80000000, 32'h80000000, 1'b0, 1'b1, 4'd1},
    '{6'h00, 6'h22, 5'd0, 16'h0000, 32'hfffffff0, 32'h00000010, 32'hffffffe0, 1'b1, 1'b0, 4'd1},
    '{6'h08, 6'h00, 5'd0, 16'h0010, 32'h7ffffff0, 32'h00000000, 32'h80000000, 1'b0, 1'b1, 4'd1},
    '{6'h08, 6'h00, 5'd0, 16'hffff, 32'h80000000, 32'h00000000, 32'h7fffffff, 1'b0, 1'b1, 4'd1},
    // R2 non-trapping forms
    '{6'h00, 6'h21, 5'd0, 16'h0000, 32'h7fffffff, 32'h00000001, 32'h80000000, 1'b1, 1'b0, 4'd2},
    '{6'h00, 6'h23, 5'd0, 16'h0000, 32'h80000000, 32'h00000001, 32'h7fffffff, 1'b1, 1'b0, 4'd2},
    '{6'h09, 6'h00, 5'd0, 16'h0001, 32'h7fffffff, 32'h00000000, 32'h80000000, 1'b1, 1'b0, 4'd2},
    // R3 immediate extension
    '{6'h0c, 6'h00, 5'd0, 16'h8001, 32'hffffffff, 32'h00000000, 32'h00008001, 1'b1, 1'b0, 4'd3},
    '{6'h0d, 6'h00, 5'd0, 16'habcd, 32'h12340000, 32'h00000000, 32'h1234abcd, 1'b1, 1'b0, 4'd3},
    '{6'h0e, 6'h00, 5'd0, 16'hffff, 32'hffff0000, 32'h00000000, 32'hffffffff, 1'b1, 1'b0, 4'd3},
    '{6'h08, 6'h00, 5'd0, 16'hfffe, 32'h0000000a, 32'h00000000, 32'h00000008, 1'b1, 1'b0, 4'd3},
    '{6'h0a, 6'h00, 5'd0, 16'hfff8, 32'hfffffff0, 32'h00000000, 32'h00000001, 1'b1, 1'b0, 4'd3},
    // R4 unsigned compare with sign-extended immediate
    '{6'h0b, 6'h00, 5'd0, 16'hffff, 32'h00000005, 32'h00000000, 32'h00000001, 1'b1, 1'b0, 4'd4},
    '{6'h0b, 6'h00, 5'd0, 16'hffff, 32'hffffffff, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 4'd4},
    '{6'h0b, 6'h00, 5'd0, 16'h8000, 32'h00009000, 32'h00000000, 32'h00000001, 1'b1, 1'b0, 4'd4},
    // R5 boolean set-less-than
    '{6'h00, 6'h2a, 5'd0, 16'h0000, 32'hffffffff, 32'h00000001, 32'h00000001, 1'b1, 1'b0, 4'd5},
    '{6'h00, 6'h2b, 5'd0, 16'h0000, 32'hffffffff, 32'h00000001, 32'h00000000, 1'b1, 1'b0, 4'd5},
    '{6'h00, 6'h2a, 5'd0, 16'h0000, 32'h00000003, 32'h00000003, 32'h00000000, 1'b1, 1'b0, 4'd5},
    // R6 variable shifts use low five bits of register s
    '{6'h00, 6'h04, 5'd0, 16'h0000, 32'h00000024, 32'h00000001, 32'h00000010, 1'b1, 1'b0, 4'd6},
    '{6'h00, 6'h06, 5'd0, 16'h0000, 32'hffffffe8, 32'h80000000, 32'h00800000, 1'b1, 1'b0, 4'd6},
    '{6'h00, 6'h07, 5'd0, 16'h0000, 32'h00000021, 32'h80000000, 32'hc0000000, 1'b1, 1'b0, 4'd6},
    // R7 fill rules
    '{6'h00, 6'h03, 5'd31, 16'h0000, 32'h00000000, 32'h80000000, 32'hffffffff, 1'b1, 1'b0, 4'd7},
    '{6'h00, 6'h03, 5'd4, 16'h0000, 32'h00000000, 32'h70000000, 32'h07000000, 1'b1, 1'b0, 4'd7},
    '{6'h00, 6'h02, 5'd4, 16'h0000, 32'h00000000, 32'hf0000000, 32'h0f000000, 1'b1, 1'b0, 4'd7},
    '{6'h00, 6'h00, 5'd8, 16'h0000, 32'h00000000, 32'h800000ff, 32'h0000ff00, 1'b1, 1'b0, 4'd7},
    // R8 load-upper
    '{6'h0f, 6'h00, 5'd0, 16'haaaa, 32'hffffffff, 32'hffffffff, 32'haaaa0000, 1'b1, 1'b0, 4'd8},
    // R9 multiply low word
    '{6'h00, 6'h18, 5'd0, 16'h0000, 32'h00010000, 32'h00010000, 32'h00000000, 1'b1, 1'b0, 4'd9},
    '{6'h00, 6'h18, 5'd0, 16'h0000, 32'hffffffff, 32'h00000002, 32'hfffffffe, 1'b1, 1'b0, 4'd9},
    '{6'h00, 6'h18, 5'd0, 16'h0000, 32'h00012345, 32'h00001000, 32'h12345000, 1'b1, 1'b0, 4'd9},
    // R10 all-zero word
    '{6'h00, 6'h00, 5'd0, 16'h0000, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 4'd10},
    // R11 encodings handled elsewhere
    '{6'h00, 6'h1a, 5'd0, 16'h0000, 32'h00000010, 32'h00000002, 32'h00000000, 1'b0, 1'b0, 4'd11},
    '{6'h00, 6'h08, 5'd0, 16'h0000, 32'h7fffffff, 32'h00000001, 32'h00000000, 1'b0, 1'b0, 4'd11},
    '{6'h23, 6'h00, 5'd0, 16'h0008, 32'h7fffffff, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 4'd11},
    // R12 register logic
    '{6'h00, 6'h24, 5'd0, 16'h0000, 32'hff00ff00, 32'h0ff00ff0, 32'h0f000f00, 1'b1, 1'b0, 4'd12},
    '{6'h00, 6'h25, 5'd0, 16'h0000, 32'hff00ff00, 32'h0ff00ff0, 32'hfff0fff0, 1'b1, 1'b0, 4'd12},
    '{6'h00, 6'h26, 5'd0, 16'h0000, 32'hff00ff00, 32'h0ff00ff0, 32'hf0f0f0f0, 1'b1, 1'b0, 4'd12},
    '{6'h00, 6'h27, 5'd0, 16'h0000, 32'h0f0f0f0f, 32'h00000000, 32'hf0f0f0f0, 1'b1, 1'b0, 4'd12},
    '{6'h00, 6'h27, 5'd0, 16'h0000, 32'h00000000, 32'h00000000, 32'hffffffff, 1'b1, 1'b0, 4'd12}
  };

  logic        clk = 1'b0;
  logic [31:0] opA, opB, result;
  logic [4:0]  shamt;
  logic [15:0] imm;
  logic [5:0]  opcode, funct;
  logic        writeEn, overflow;
  int          nChecks = 0;
  int          nFails  = 0;
  int          cycles  = 0;

  always #4 clk = ~clk;

  int_exec_unit u_dut (
    .opA(opA), .opB(opB), .shamt(shamt), .imm(imm),
    .opcode(opcode), .funct(funct),
    .result(result), .writeEn(writeEn), .overflow(overflow)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic applyAndCheck(input vec_t v, input int idx);
    @(posedge clk);
    opcode = v.opc; funct = v.fn; shamt = v.sh; imm = v.imm; opA = v.a; opB = v.b;
    @(negedge clk);
    nChecks = nChecks + 1;
    if (result !== v.res || writeEn !== v.we || overflow !== v.ov) begin
      nFails = nFails + 1;
      $display("FAIL R%0d vec %0d: result=%h/%h writeEn=%b/%b overflow=%b/%b (actual/expected)",
               v.req, idx, result, v.res, writeEn, v.we, overflow, v.ov);
    end
  endtask

  initial begin
    opcode = '0; funct = '0; shamt = '0; imm = '0; opA = '0; opB = '0;
    // R10: idle all-zero inputs give a quiet zero output
    @(negedge clk);
    nChecks = nChecks + 1;
    if (result !== 32'h0 || overflow !== 1'b0) begin
      nFails = nFails + 1;
      $display("FAIL R10 idle: result=%h/%h overflow=%b/%b", result, 32'h0, overflow, 1'b0);
    end

    for (int i = 0; i < NV; i++) applyAndCheck(VECS[i], i);

    // R6: sweep upper bits of register s, distance fixed at 3
    for (int k = 0; k < 8; k++) begin
      applyAndCheck('{6'h00, 6'h04, 5'd0, 16'h0, {k[2:0], 24'h0, 5'd3}, 32'h00000001,
                      32'h00000008, 1'b1, 1'b0, 4'd6}, 100 + k);
    end
    // R1 and R2: same overflowing pair through trapping and non-trapping subtract
    applyAndCheck('{6'h00, 6'h22, 5'd0, 16'h0, 32'h7fffffff, 32'hffffffff,
                    32'h80000000, 1'b0, 1'b1, 4'd1}, 200);
    applyAndCheck('{6'h00, 6'h23, 5'd0, 16'h0, 32'h7fffffff, 32'hffffffff,
                    32'h80000000, 1'b1, 1'b0, 4'd2}, 201);
    // R8: load-upper ignores both operands
    applyAndCheck('{6'h0f, 6'h00, 5'd7, 16'h1234, 32'h0000ffff, 32'h0000ffff,
                    32'h12340000, 1'b1, 1'b0, 4'd8}, 202);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule